// File: doc/BRIEF.md
# Oversampling serial link receiver

This block recovers packets from a single asynchronous serial wire using a local clock that runs several times faster than the bit rate. The wire rests low. Each packet opens with a high start bit. The bit that follows the start bit sets the packet kind. A high second bit marks a data packet: eight payload bits follow, least significant first, and then a low stop bit. A low second bit marks a two-bit acknowledge, which ends at that bit.

The input passes through a synchroniser. The receiver then waits for a low-to-high transition and times every later bit from that transition, sampling each one at its nominal centre. A finished data packet produces a one-cycle `byte_valid` pulse and updates `byte_data`. An acknowledge produces a one-cycle `ack_seen` pulse and never reaches the byte output. A data packet whose stop bit reads high produces a `frame_err` pulse and is discarded.

The rate is picked per packet. With `speed_fast` low a bit lasts `OSR_SLOW` local clocks; with it high a bit lasts half that. `OSR_SLOW` must be a multiple of four and at least eight.

Top module: `serial_link_rx`

## Requirements
- R1: While `rst_n` is low, `byte_valid`, `ack_seen` and `frame_err` are low and `byte_data` is zero.
- R2: A data packet (high start, high kind bit, eight payload bits least significant first, low stop) gives exactly one `byte_valid` pulse of one cycle, with `byte_data` equal to the payload. `byte_data` then holds that value until the next such pulse.
- R3: A packet whose kind bit is low gives exactly one `ack_seen` pulse of one cycle. It gives no `byte_valid`, and `byte_data` keeps its previous value.
- R4: Let E0 be the first rising clock edge at which the high start bit is present on `link_in`, let S be `SYNC_STAGES`, and let N be the bit length in clocks. The event pulse is visible in the cycle after edge E0 + S + k·N + N/2, with k = 1 for an acknowledge and k = 10 for a data packet.
- R5: Each bit after the start bit is judged only by its value N/2 clocks into the bit. The bit's first clock and last clock may carry the opposite level without changing the result.
- R6: A data packet whose stop bit samples high gives one `frame_err` pulse of one cycle at the R4 data position. It gives no `byte_valid`, and `byte_data` is left unchanged.
- R7: N is `OSR_SLOW` when `speed_fast` is low and `OSR_SLOW/2` when it is high. The value is taken at the edge that accepts the start transition and is held for the whole packet, so a change of `speed_fast` in mid-packet has no effect on that packet.
- R8: After a packet ends, a line that stays high starts no new packet. Reception resumes only after the line goes low and then high again.
- R9: A packet may start in the bit period that directly follows the previous packet's last bit, at either rate, and is still received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_fast | input | 1 | Rate select: 1 gives OSR_SLOW/2 clocks per bit, 0 gives OSR_SLOW |
| link_in | input | 1 | Asynchronous serial input, idles low |
| byte_valid | output | 1 | One-cycle pulse when a data packet completes correctly |
| byte_data | output | DATA_BITS | Last received payload |
| ack_seen | output | 1 | One-cycle pulse when an acknowledge packet completes |
| frame_err | output | 1 | One-cycle pulse when a data packet's stop bit reads high |

## Verification
The bench drives bit edges that carry opposite-level glitches in their first and last clocks. A receiver that sampled off centre would return corrupted bytes. It also starts packets in the bit period right after the previous packet ends, at both rates. A receiver that returned to idle late would miss those start transitions. It holds the line high after a failed stop bit, which a receiver that started on a level rather than an edge would turn into phantom packets. Finally, it flips the rate input in mid-packet, which would shift every later sample if the rate were not held for the packet.

// File: rtl/slr_pkg.sv
package slr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KIND = 2'd1,
        ST_DATA = 2'd2,
        ST_STOP = 2'd3
    } slr_state_e;

    // Clocks from start acceptance to the centre of the kind bit, minus one
    function automatic int unsigned first_wait(input int unsigned clks_per_bit);
        return (3 * clks_per_bit) / 2 - 1;
    endfunction

endpackage

// File: rtl/slr_sync.sv
module slr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t q, d;
    logic [STAGES-1:0] chain_next;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_next = din;
        end else begin : g_many
            assign chain_next = {q.chain[STAGES-2:0], din};
        end
    endgenerate

    always_comb begin
        d       = q;
        d.chain = chain_next;
        d.prev  = q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout = q.chain[STAGES-1];
    assign rise = q.chain[STAGES-1] & ~q.prev;

endmodule

// File: rtl/slr_bit_timer.sv
module slr_bit_timer #(
    parameter int unsigned OSR_SLOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int unsigned OSR_FAST = OSR_SLOW / 2;
    localparam int unsigned CW       = $clog2((3 * OSR_SLOW) / 2);
    localparam logic [CW-1:0] LOAD_SLOW   = CW'(slr_pkg::first_wait(OSR_SLOW));
    localparam logic [CW-1:0] LOAD_FAST   = CW'(slr_pkg::first_wait(OSR_FAST));
    localparam logic [CW-1:0] RELOAD_SLOW = CW'(OSR_SLOW - 1);
    localparam logic [CW-1:0] RELOAD_FAST = CW'(OSR_FAST - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = fast ? LOAD_FAST : LOAD_SLOW;
        end else if (run) begin
            if (q.cnt == '0) begin
                d.cnt = fast ? RELOAD_FAST : RELOAD_SLOW;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick = run && (q.cnt == '0);

endmodule

// File: rtl/slr_frame.sv
module slr_frame #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx,
    input  logic                 rx_rise,
    input  logic                 tick,
    input  logic                 speed_in,
    output logic                 load,
    output logic                 run,
    output logic                 fast_sel,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 ack_seen,
    output logic                 frame_err
);

    import slr_pkg::*;

    localparam int unsigned NW = $clog2(DATA_BITS);
    localparam logic [NW-1:0] LAST_BIT = NW'(DATA_BITS - 1);

    typedef struct packed {
        slr_state_e           state;
        logic                 spd;
        logic [DATA_BITS-1:0] shreg;
        logic [NW-1:0]        nbits;
        logic [DATA_BITS-1:0] dout;
        logic                 bv;
        logic                 ack;
        logic                 ferr;
    } frm_t;

    frm_t q, d;

    always_comb begin
        d      = q;
        d.bv   = 1'b0;
        d.ack  = 1'b0;
        d.ferr = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (rx_rise) begin
                    d.state = ST_KIND;
                    d.spd   = speed_in;
                end
            end
            ST_KIND: begin
                if (tick) begin
                    if (rx) begin
                        d.state = ST_DATA;
                        d.nbits = '0;
                    end else begin
                        d.ack   = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    d.shreg = {rx, q.shreg[DATA_BITS-1:1]};
                    if (q.nbits == LAST_BIT) begin
                        d.state = ST_STOP;
                    end else begin
                        d.nbits = q.nbits + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.state = ST_IDLE;
                    if (!rx) begin
                        d.bv   = 1'b1;
                        d.dout = q.shreg;
                    end else begin
                        d.ferr = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign load       = (q.state == ST_IDLE) && rx_rise;
    assign run        = (q.state != ST_IDLE);
    assign fast_sel   = (q.state == ST_IDLE) ? speed_in : q.spd;
    assign byte_valid = q.bv;
    assign byte_data  = q.dout;
    assign ack_seen   = q.ack;
    assign frame_err  = q.ferr;

endmodule

// File: rtl/serial_link_rx.sv
module serial_link_rx #(
    parameter int unsigned OSR_SLOW    = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 speed_fast,
    input  logic                 link_in,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 ack_seen,
    output logic                 frame_err
);

    logic rx_s;
    logic rx_rise;
    logic tick;
    logic load;
    logic run;
    logic fast_sel;

    slr_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (link_in),
        .dout  (rx_s),
        .rise  (rx_rise)
    );

    slr_bit_timer #(
        .OSR_SLOW (OSR_SLOW)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .run   (run),
        .fast  (fast_sel),
        .tick  (tick)
    );

    slr_frame #(
        .DATA_BITS (DATA_BITS)
    ) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx         (rx_s),
        .rx_rise    (rx_rise),
        .tick       (tick),
        .speed_in   (speed_fast),
        .load       (load),
        .run        (run),
        .fast_sel   (fast_sel),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .ack_seen   (ack_seen),
        .frame_err  (frame_err)
    );

endmodule

// File: rtl/serial_link_rx_chk.sv
module serial_link_rx_chk #(
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 byte_valid,
    input logic [DATA_BITS-1:0] byte_data,
    input logic                 ack_seen,
    input logic                 frame_err
);

    // R3
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_valid, ack_seen, frame_err}));

    // R2
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> !ack_seen);

    // R3
    ack_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |-> $stable(byte_data));

    // R6
    ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R6
    ferr_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $stable(byte_data));

endmodule

bind serial_link_rx serial_link_rx_chk #(
    .DATA_BITS (DATA_BITS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .ack_seen   (ack_seen),
    .frame_err  (frame_err)
);

// File: tb/serial_link_rx_tb_top.sv
module serial_link_rx_tb_top;

    localparam int unsigned OSR  = 8;
    localparam int unsigned SYNC = 2;
    localparam int NS = OSR;
    localparam int NF = OSR / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_fast = 1'b0;
    logic       link_in = 1'b0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       ack_seen;
    logic       frame_err;

    serial_link_rx #(
        .OSR_SLOW    (OSR),
        .SYNC_STAGES (SYNC),
        .DATA_BITS   (8)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_fast (speed_fast),
        .link_in    (link_in),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .ack_seen   (ack_seen),
        .frame_err  (frame_err)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         checking = 1'b0;
    bit         done = 1'b0;
    logic [7:0] last_byte = 8'h00;
    string      phase = "reset";

    // Reference model: events keyed by the cycle in which they must be visible
    bit         exp_bv  [int];
    logic [7:0] exp_dat [int];
    bit         exp_ack [int];
    bit         exp_fe  [int];
    bit         eb, ea, ef;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) cycle %0d: got %0h expected %0h", req, phase, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            eb = exp_bv.exists(cyc);
            ea = exp_ack.exists(cyc);
            ef = exp_fe.exists(cyc);
            chk("R2 byte_valid", {31'd0, byte_valid}, {31'd0, eb});
            chk("R3 ack_seen", {31'd0, ack_seen}, {31'd0, ea});
            chk("R6 frame_err", {31'd0, frame_err}, {31'd0, ef});
            if (eb) begin
                last_byte = exp_dat[cyc];
                chk("R2 byte_data", {24'd0, byte_data}, {24'd0, last_byte});
            end else begin
                chk("R3 byte_data held", {24'd0, byte_data}, {24'd0, last_byte});
            end
        end
    end

    // Drives one packet; records when its event must appear (R4)
    task automatic send(input bit is_data, input logic [7:0] b, input bit stop_v,
                        input int n, input bit glitch, input bit flip);
        logic bits [11];
        int   nb;
        int   e0;
        int   kend;
        int   at;
        bits[0] = 1'b1;
        bits[1] = is_data;
        for (int i = 0; i < 8; i++) bits[2+i] = b[i];
        bits[10] = stop_v;
        nb = is_data ? 11 : 2;
        for (int k = 0; k < nb; k++) begin
            for (int j = 0; j < n; j++) begin
                @(negedge clk);
                if (k == 0 && j == 0) begin
                    e0   = cyc + 1;
                    kend = is_data ? 10 : 1;
                    at   = e0 + SYNC + kend * n + n / 2;
                    if (!is_data) begin
                        exp_ack[at] = 1'b1;
                    end else if (!stop_v) begin
                        exp_bv[at]  = 1'b1;
                        exp_dat[at] = b;
                    end else begin
                        exp_fe[at] = 1'b1;
                    end
                end
                if (flip && k == 3 && j == 0) speed_fast = ~speed_fast;
                // R5: corrupt the edges of a bit, never its centre
                if (glitch && k >= 1 && k <= 9 && (j == 0 || (j == n - 1 && k >= 2)))
                    link_in = ~bits[k];
                else
                    link_in = bits[k];
            end
        end
    endtask

    task automatic idle(input int c);
        repeat (c) begin
            @(negedge clk);
            link_in = 1'b0;
        end
    endtask

    task automatic hold_high(input int c);
        repeat (c) begin
            @(negedge clk);
            link_in = 1'b1;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        phase = "R1 reset";
        chk("R1 byte_valid", {31'd0, byte_valid}, 32'd0);
        chk("R1 ack_seen", {31'd0, ack_seen}, 32'd0);
        chk("R1 frame_err", {31'd0, frame_err}, 32'd0);
        chk("R1 byte_data", {24'd0, byte_data}, 32'd0);
        @(negedge clk);
        rst_n    = 1'b1;
        checking = 1'b1;
        idle(5);

        phase = "R2 R4 slow data";
        send(1'b1, 8'hA5, 1'b0, NS, 1'b0, 1'b0);
        idle(6);
        phase = "R3 slow ack";
        send(1'b0, 8'h00, 1'b0, NS, 1'b0, 1'b0);
        idle(6);

        speed_fast = 1'b1;
        phase = "R7 fast data and ack";
        send(1'b1, 8'h3C, 1'b0, NF, 1'b0, 1'b0);
        idle(4);
        send(1'b0, 8'h00, 1'b0, NF, 1'b0, 1'b0);
        idle(4);
        phase = "R5 glitched fast";
        send(1'b1, 8'h5A, 1'b0, NF, 1'b1, 1'b0);
        idle(4);

        speed_fast = 1'b0;
        phase = "R5 glitched slow";
        send(1'b1, 8'h96, 1'b0, NS, 1'b1, 1'b0);
        idle(4);

        phase = "R6 R8 high stop then held high";
        send(1'b1, 8'hFF, 1'b1, NS, 1'b0, 1'b0);
        hold_high(40);
        idle(6);
        send(1'b1, 8'h01, 1'b0, NS, 1'b0, 1'b0);
        idle(6);

        phase = "R9 back-to-back slow";
        send(1'b1, 8'h80, 1'b0, NS, 1'b0, 1'b0);
        send(1'b0, 8'h00, 1'b0, NS, 1'b0, 1'b0);
        send(1'b1, 8'h7E, 1'b0, NS, 1'b0, 1'b0);
        idle(6);

        speed_fast = 1'b1;
        phase = "R9 back-to-back fast";
        send(1'b0, 8'h00, 1'b0, NF, 1'b0, 1'b0);
        send(1'b0, 8'h00, 1'b0, NF, 1'b0, 1'b0);
        send(1'b1, 8'hC3, 1'b0, NF, 1'b0, 1'b0);
        send(1'b1, 8'h24, 1'b0, NF, 1'b0, 1'b0);
        idle(6);

        speed_fast = 1'b0;
        phase = "R7 rate held while flipped (slow start)";
        send(1'b1, 8'h6B, 1'b0, NS, 1'b0, 1'b1);
        idle(6);
        speed_fast = 1'b1;
        phase = "R7 rate held while flipped (fast start)";
        speed_fast = 1'b1;
        send(1'b1, 8'hD2, 1'b0, NF, 1'b0, 1'b1);
        idle(6);
        speed_fast = 1'b0;

        idle(30);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (%s): run did not complete", phase);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule